// File: doc/BRIEF.md
# Multiplexed Display and Keypad Scanner

This block refreshes a six-position multiplexed fluorescent display and, in the same pass, reads a key matrix whose rows are wired to the display's digit-select lines. A host loads one segment pattern per digit through a write port made of an address, a data word and a write strobe. The block shows the digits one at a time. A prescaler sets the rate at which it steps from one digit to the next. Each digit is separated from the next by a short blanking gap.

While a digit is lit, its active-low select line also pulls one row of the key matrix low. Any key that is pressed on that row pulls its return line low. The return lines go through a two-stage synchronizer and are captured near the end of the slot into that row's entry of a six-entry key image. The host reads the image through a combinational read port. A one-clock done pulse marks the end of each full pass, after the last row has been captured.

Top module: `disp_key_scan`

## Requirements
- R1: `dig_n` is active low. At most one bit of `dig_n` is low at any time, and every other bit is high.
- R2: Each digit slot lasts `TICK_DIV` clocks. Digits are served in index order 0,1,...,5 and then wrap to 0. Digit i is driven on `dig_n[i]`.
- R3: For the first `BLANK_CYC` clocks of every slot, all of `dig_n` is high and `seg_out` is zero. For the rest of the slot, only the slot's digit is low.
- R4: While digit i is lit, `seg_out` shows the segment word last written to address i. A write to an address above 5 has no effect on any digit.
- R5: A segment write to a digit that is currently lit does not change `seg_out` during that slot. It takes effect the next time that digit is lit.
- R6: Two clocks before the end of slot i, the synchronized `key_ret_n` is stored in key entry i, where a low bit means pressed. `rd_data` equals key entry `rd_addr` with no delay. An address above 5 reads zero.
- R7: A key entry holds its last captured value until its own row is scanned again, even if the keys change in the meantime.
- R8: `scan_done` is high for exactly one clock. That clock is the last clock of digit 5's slot, the clock after row 5 is captured.
- R9: Synchronous reset clears every segment word and every key entry, drives `dig_n` all high and `seg_out` to zero, and restarts the scan at the start of digit 0's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Segment write strobe |
| wr_addr | input | ADDR_W | Digit index to write |
| wr_data | input | SEG_W | Segment word |
| rd_addr | input | ADDR_W | Key row to read |
| rd_data | output | KEY_W | Key entry of the selected row, low = pressed |
| key_ret_n | input | KEY_W | Key matrix return lines, active low |
| seg_out | output | SEG_W | Segment bus, zero while blank |
| dig_n | output | NUM_DIGITS | Digit select and key row drive, active low |
| scan_done | output | 1 | One-clock pulse at the end of each full pass |

## Verification
The bench models the key matrix from `dig_n`. It drives the matrix with several key patterns: no key pressed, a single key, one key per row on a diagonal, and a distinct multi-bit word on each row. Together these show apart a row swap, a column swap, a missing inversion and a capture into the wrong entry. The bench compares the segment bus on every cycle against a set of segment patterns that all differ from each other, so a wrong digit index or a slip in blanking shows up at once. Two further tests cover timing: one writes to a digit while it is lit, and one changes the keys halfway through a pass. These show apart a design that captures or displays at the right moment from one that acts a slot too early.

// File: rtl/disp_key_scan.sv
module disp_key_scan #(
  parameter int NUM_DIGITS = 6,
  parameter int SEG_W      = 8,
  parameter int KEY_W      = 8,
  parameter int TICK_DIV   = 125000,
  parameter int BLANK_CYC  = 2,
  parameter int ADDR_W     = $clog2(NUM_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [SEG_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [KEY_W-1:0]      rd_data,
  input  logic [KEY_W-1:0]      key_ret_n,
  output logic [SEG_W-1:0]      seg_out,
  output logic [NUM_DIGITS-1:0] dig_n,
  output logic                  scan_done
);
  localparam int CNT_W = $clog2(TICK_DIV);
  localparam logic [ADDR_W-1:0] LAST    = ADDR_W'(NUM_DIGITS - 1);
  localparam logic [CNT_W-1:0]  P_END   = CNT_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0]  P_SAMP  = CNT_W'(TICK_DIV - 2);
  localparam logic [CNT_W-1:0]  P_SHOW  = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0]  P_LIT   = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0]  pre_cnt;
  logic [ADDR_W-1:0] cur;
  logic [SEG_W-1:0]  seg_mem [NUM_DIGITS];
  logic [KEY_W-1:0]  key_img [NUM_DIGITS];
  logic [KEY_W-1:0]  ks1, ks2;
  logic [SEG_W-1:0]  seg_q;
  logic              done_q;

  wire slot_end = (pre_cnt == P_END);
  wire sample   = (pre_cnt == P_SAMP);
  wire show     = (pre_cnt == P_SHOW);
  wire blank    = (pre_cnt < P_LIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      cur     <= '0;
      seg_q   <= '0;
      done_q  <= 1'b0;
      ks1     <= '1;
      ks2     <= '1;
      for (int i = 0; i < NUM_DIGITS; i++) begin
        seg_mem[i] <= '0;
        key_img[i] <= '0;
      end
    end else begin
      ks1     <= key_ret_n;
      ks2     <= ks1;
      pre_cnt <= slot_end ? '0 : pre_cnt + 1'b1;
      if (slot_end)
        cur <= (cur == LAST) ? '0 : cur + 1'b1;
      if (slot_end)
        seg_q <= '0;
      else if (show)
        seg_q <= seg_mem[cur];
      if (sample)
        key_img[cur] <= ks2;
      done_q <= sample && (cur == LAST);
      if (wr_en && (wr_addr <= LAST))
        seg_mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
    assign dig_n[g] = blank | (cur != ADDR_W'(g));
  end

  assign seg_out   = seg_q;
  assign scan_done = done_q;
  assign rd_data   = (rd_addr <= LAST) ? key_img[rd_addr] : '0;
endmodule

// File: rtl/disp_key_scan_chk.sv
module disp_key_scan_chk #(
  parameter int NUM_DIGITS = 6,
  parameter int SEG_W      = 8,
  parameter int ADDR_W     = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_DIGITS-1:0] dig_n,
  input logic [SEG_W-1:0]      seg_out,
  input logic                  scan_done,
  input logic [ADDR_W-1:0]     cur
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_DIGITS - 1);

  // R1
  one_low_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_n));

  // R3
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dig_n != '1) |=> ((dig_n == '1) || $stable(dig_n)));

  // R3
  seg_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (dig_n == '1) |-> (seg_out == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  // R8
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (cur == LAST));
endmodule

bind disp_key_scan disp_key_scan_chk #(
  .NUM_DIGITS(NUM_DIGITS), .SEG_W(SEG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .dig_n(dig_n), .seg_out(seg_out),
  .scan_done(scan_done), .cur(cur)
);

// File: tb/disp_key_scan_bench.sv
module disp_key_scan_bench;
  localparam int N  = 6;
  localparam int SW = 8;
  localparam int KW = 8;
  localparam int T  = 20;
  localparam int B  = 2;
  localparam int AW = 3;
  localparam int P  = N * T;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [SW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [KW-1:0] rd_data;
  logic [KW-1:0] key_ret_n;
  logic [SW-1:0] seg_out;
  logic [N-1:0]  dig_n;
  logic          scan_done;

  logic [KW-1:0] press [N];
  logic [KW-1:0] pat_a [N];
  logic [SW-1:0] segm [N];
  logic [SW-1:0] shown;
  int cyc, vecs, bad;
  bit chk_on;

  always #10 clk = ~clk;

  disp_key_scan #(.NUM_DIGITS(N), .SEG_W(SW), .KEY_W(KW), .TICK_DIV(T),
                  .BLANK_CYC(B)) u_disp_key_scan (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .key_ret_n(key_ret_n),
    .seg_out(seg_out), .dig_n(dig_n), .scan_done(scan_done));

  always_comb begin
    key_ret_n = '1;
    for (int r = 0; r < N; r++)
      if (!dig_n[r]) key_ret_n = key_ret_n & ~press[r];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic tick();
    int pre, cur;
    logic [N-1:0] ed;
    @(negedge clk);
    cyc++;
    pre = cyc % T;
    cur = (cyc / T) % N;
    if (pre == 0) shown = '0;
    if (pre == B) shown = segm[cur];
    if (chk_on) begin
      ed = '1;
      if (pre >= B) ed[cur] = 1'b0;
      chk(dig_n == ed, (pre < B) ? "R3 blank select" : "R1 R2 select", 32'(dig_n), 32'(ed));
      chk(seg_out == shown, (pre < B) ? "R3 blank segments" : "R4 segments",
          32'(seg_out), 32'(shown));
      chk(scan_done == ((cyc % P) == P - 1), "R8 scan_done", 32'(scan_done),
          32'((cyc % P) == P - 1));
    end
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  task automatic wait_to(input int m);
    while ((cyc % P) != m) tick();
  endtask

  task automatic wr(input int a, input logic [SW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
    if (a < N) segm[a] = d;
  endtask

  task automatic rd(input int a, input logic [KW-1:0] exp, input string tag);
    rd_addr = AW'(a);
    #1;
    chk(rd_data === exp, tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic do_reset(input int hold);
    chk_on = 1'b0;
    rst = 1'b1;
    repeat (hold) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    shown = '0;
    for (int i = 0; i < N; i++) segm[i] = '0;
    chk_on = 1'b1;
  endtask

  task automatic t_reset_state();
    chk(dig_n == '1, "R9 reset selects", 32'(dig_n), 32'h3f);
    chk(seg_out == '0, "R9 reset segments", 32'(seg_out), 0);
    chk(scan_done == 1'b0, "R9 reset done", 32'(scan_done), 0);
    for (int r = 0; r < N; r++) rd(r, '0, "R9 reset key image");
    run(B);
    chk(dig_n == 6'b111110, "R9 restart at digit 0", 32'(dig_n), 32'h3e);
  endtask

  task automatic t_segments();
    for (int i = 0; i < N; i++) wr(i, SW'(8'h11 * (i + 1)) ^ SW'(i << 7));
    wr(6, 8'hff);
    wr(7, 8'hee);
    run(2 * P + 5);
  endtask

  task automatic t_write_timing();
    logic [SW-1:0] old;
    old = segm[3];
    wait_to(3 * T + 8);
    wr(3, 8'h5a);
    run(3);
    chk(seg_out == old, "R5 lit digit keeps old word", 32'(seg_out), 32'(old));
    wait_to(3 * T + B + 1);
    chk(seg_out == 8'h5a, "R5 new word on next visit", 32'(seg_out), 32'h5a);
  endtask

  task automatic t_keys(input string name);
    wait_to(0);
    run(P);
    for (int r = 0; r < N; r++) rd(r, ~press[r], {"R6 key image ", name});
  endtask

  task automatic t_stale();
    for (int r = 0; r < N; r++) pat_a[r] = press[r];
    wait_to(0);
    for (int r = 0; r < N; r++) press[r] = KW'(8'h3c ^ (r * 17));
    wait_to(2 * T + 10);
    rd(0, ~press[0], "R7 rescanned row 0");
    rd(1, ~press[1], "R7 rescanned row 1");
    for (int r = 2; r < N; r++) rd(r, ~pat_a[r], "R7 row not yet rescanned");
    run(P);
  endtask

  task automatic t_reset_mid();
    wait_to(4 * T + 9);
    do_reset(2);
    chk(dig_n == '1, "R9 mid reset selects", 32'(dig_n), 32'h3f);
    chk(seg_out == '0, "R9 mid reset segments", 32'(seg_out), 0);
    for (int r = 0; r < N; r++) rd(r, '0, "R9 mid reset key image");
    run(B);
    chk(dig_n == 6'b111110, "R9 scan restarts at digit 0", 32'(dig_n), 32'h3e);
    run(P);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog R1-related run hung: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    vecs = 0; bad = 0; cyc = 0; chk_on = 1'b0; shown = '0;
    for (int r = 0; r < N; r++) begin press[r] = '0; segm[r] = '0; end
    do_reset(3);
    t_reset_state();
    t_segments();
    t_write_timing();
    t_keys("none pressed");
    press[2] = 8'h20;
    t_keys("single key");
    for (int r = 0; r < N; r++) press[r] = KW'(1 << r);
    t_keys("diagonal");
    for (int r = 0; r < N; r++) press[r] = KW'(8'ha5 + r * 8'h13);
    t_keys("distinct words");
    rd(7, '0, "R6 out-of-range read");
    t_stale();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule